// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is a slave on a two-wire serial bus with open-drain lines. It oversamples the clock and data lines with the system clock and detects start and stop conditions. It then takes in an address byte and checks it against a fixed six-bit control code and one strap input. Once it is addressed, it serves reads and writes against a 256-byte address space that a downstream storage controller holds. Write data leaves as a one-cycle strobe with an address and a byte. Read data comes back combinationally for the address the block presents.

The block keeps a byte pointer between transactions. A write loads the pointer from the first byte after the address byte. Each further written byte advances only the pointer's lowest three bits, so writes stay inside one eight-byte page. A read starts at the pointer and steps through the full space, wrapping from FFh to 00h. A start condition seen at any moment abandons the transfer in progress. A busy input, raised while the storage controller is occupied, makes the slave ignore every address byte.

Top module: `tws_reg_slave`

## Requirements
- R1: The address byte is received MSB first and is accepted only when its upper six bits are 101000 and bit 1 equals `strap_sel`. Bit 0 set to 1 selects a read and 0 selects a write. An accepted byte is acknowledged by holding SDA low through the ninth clock.
- R2: An address byte whose bit 1 differs from `strap_sel` is not acknowledged. The bytes that follow before the next start are ignored: they get no acknowledge and cause no write strobe.
- R3: While `busy` is high at the end of an address byte, that byte is not acknowledged. Once `busy` is low, addressing works again.
- R4: In a write, the first byte after the address byte loads the pointer and each later byte is data. Every one of these bytes is acknowledged. Each data byte gives one `wr_stb` pulse with `wr_addr` equal to the pointer and `wr_data` equal to the byte.
- R5: After each data byte, the pointer's three low bits increment and its upper five bits are held. A write running past the end of an eight-byte page therefore wraps to that page's first byte.
- R6: A read that has no address write before it returns the byte at the pointer. The pointer holds the last accessed address plus one.
- R7: A random read is made of a write of the address byte and a pointer byte, then a repeated start, then an address byte with bit 0 set to 1. It returns the byte at the loaded address.
- R8: The pointer advances by one after each transmitted read byte and wraps from FFh to 00h. A master acknowledge causes the next byte to be sent.
- R9: After a read byte that the master does not acknowledge, SDA stays released until the next start. The pointer still ends at the address after the last byte sent.
- R10: A start condition at any point aborts the current transfer and begins address reception. A byte that was only partly received causes no write and no pointer load.
- R11: SCL and SDA each pass through two synchronizer flip-flops. The SDA output enable changes only while the synchronized SCL is low.
- R12: After reset, SDA is released, `wr_stb` is low and the pointer is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| strap_sel | input | 1 | Strap bit compared with address bit 1 |
| busy | input | 1 | High makes the slave ignore address bytes |
| wr_stb | output | 1 | One-cycle write strobe per data byte |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| rd_addr | output | 8 | Current pointer, address of the byte to read |
| rd_data | input | 8 | Read data returned for `rd_addr` |

## Verification
On every cycle the assertions check the following. The data-line drive changes only while the synchronized clock is low. A write strobe lasts one cycle, and the pointer afterwards has moved to the next byte of the same page. Any start sends the slave back to address reception, and the line is never driven while idle. Only the bench's bus scenarios can show the rest: the acknowledges for matching and mismatched addresses and during busy, the data flowing through the page wrap and the FFh-to-00h wrap, the pointer carried across transactions, and the absence of writes after an aborted byte.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam logic [5:0] CTRL_CODE = 6'b101000;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RX_ADDR,
        S_RX_REG,
        S_RX_DATA,
        S_ACK_WAIT,
        S_ACK_DRV,
        S_TX,
        S_MACK,
        S_MACK_OK
    } state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync
    import tws_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        ev.scl      = scl_sh[STAGES-1];
        ev.sda      = sda_sh[STAGES-1];
        ev.scl_rise = ev.scl & ~scl_q;
        ev.scl_fall = ~ev.scl & scl_q;
        ev.start    = ev.scl & scl_q & sda_q & ~ev.sda;
        ev.stop     = ev.scl & scl_q & ~sda_q & ev.sda;
    end
endmodule

// File: rtl/tws_addr_ptr.sv
module tws_addr_ptr #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_page,
    input  logic          step_seq,
    output logic [AW-1:0] ptr
);
    logic [AW-1:0] page_next;

    generate
        if (PAGE_BITS >= AW) begin : g_flat
            assign page_next = ptr + 1'b1;
        end else begin : g_paged
            assign page_next = {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + 1'b1};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_page) ptr <= page_next;
        else if (step_seq)  ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/tws_reg_slave.sv
module tws_reg_slave
    import tws_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PAGE_BITS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          strap_sel,
    input  logic          busy,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data
);
    localparam int BIT_LAST = 7;

    line_ev_t      ev;
    state_t        st;
    state_t        nxt;
    logic [3:0]    cnt;
    logic [7:0]    sh;
    logic [7:0]    rx_byte;
    logic [AW-1:0] ptr;
    logic          byte_done;
    logic          ptr_load;
    logic          ptr_page;
    logic          ptr_seq;
    logic          addr_hit;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    assign rx_byte   = {sh[6:0], ev.sda};
    assign byte_done = ev.scl_rise && (cnt == 4'(BIT_LAST));
    assign addr_hit  = (rx_byte[7:1] == {CTRL_CODE, strap_sel}) && !busy;
    assign ptr_load  = !ev.start && !ev.stop && (st == S_RX_REG) && byte_done;
    assign ptr_page  = !ev.start && !ev.stop && (st == S_RX_DATA) && byte_done;
    assign ptr_seq   = !ev.start && !ev.stop && (st == S_TX) && ev.scl_fall && (cnt == 4'd8);

    tws_addr_ptr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ptr_load),
        .load_val  (rx_byte[AW-1:0]),
        .step_page (ptr_page),
        .step_seq  (ptr_seq),
        .ptr       (ptr)
    );

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            nxt     <= S_IDLE;
            cnt     <= '0;
            sh      <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev.start) begin
                st     <= S_RX_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    S_RX_ADDR, S_RX_REG, S_RX_DATA: begin
                        if (ev.scl_rise) begin
                            sh <= rx_byte;
                            if (cnt == 4'(BIT_LAST)) begin
                                cnt <= '0;
                                if (st == S_RX_ADDR) begin
                                    if (addr_hit) begin
                                        nxt <= rx_byte[0] ? S_TX : S_RX_REG;
                                        st  <= S_ACK_WAIT;
                                    end else begin
                                        st  <= S_IDLE;
                                    end
                                end else if (st == S_RX_REG) begin
                                    nxt <= S_RX_DATA;
                                    st  <= S_ACK_WAIT;
                                end else begin
                                    wr_stb  <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx_byte;
                                    nxt     <= S_RX_DATA;
                                    st      <= S_ACK_WAIT;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    S_ACK_WAIT: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b1;
                            st     <= S_ACK_DRV;
                        end
                    end
                    S_ACK_DRV: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (nxt == S_TX) begin
                                sh     <= rd_data;
                                sda_oe <= ~rd_data[7];
                                st     <= S_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= nxt;
                            end
                        end
                    end
                    S_TX: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                st     <= S_MACK;
                            end else begin
                                sh     <= {sh[6:0], 1'b0};
                                sda_oe <= ~sh[6];
                            end
                        end
                    end
                    S_MACK: begin
                        if (ev.scl_rise) begin
                            st <= ev.sda ? S_IDLE : S_MACK_OK;
                        end
                    end
                    S_MACK_OK: begin
                        if (ev.scl_fall) begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            cnt    <= '0;
                            st     <= S_TX;
                        end
                    end
                    default: begin
                        st <= S_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/tws_reg_slave_chk.sv
module tws_reg_slave_chk
    import tws_pkg::*;
#(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_lvl,
    input logic          start_ev,
    input logic          sda_oe,
    input logic          wr_stb,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] ptr,
    input state_t        st
);
    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    // R4
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R5
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> (ptr[AW-1:PAGE_BITS] == wr_addr[AW-1:PAGE_BITS]) &&
                   (ptr[PAGE_BITS-1:0] == wr_addr[PAGE_BITS-1:0] + 1'b1));

    // R10
    start_abort_chk: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (st == S_RX_ADDR));

    // R9
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> !sda_oe);
endmodule

bind tws_reg_slave tws_reg_slave_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_lvl  (ev.scl),
    .start_ev (ev.start),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .ptr      (ptr),
    .st       (st)
);

// File: tb/tws_reg_slave_bench.sv
module tws_reg_slave_bench;
    localparam int Q = 10;
    localparam logic [7:0] A_W  = 8'hA2;
    localparam logic [7:0] A_R  = 8'hA3;
    localparam logic [7:0] A_MM = 8'hA0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       m_low = 1'b0;
    logic       strap_sel = 1'b1;
    logic       busy = 1'b0;
    logic       sda_oe;
    logic       wr_stb;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    wire        sda_line;

    logic [7:0] mem  [0:255];
    logic [7:0] expm [0:255];
    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int viol = 0;
    logic prev_oe = 1'b0;
    logic done = 1'b0;

    assign sda_line = ~(sda_oe | m_low);
    assign rd_data  = mem[rd_addr];

    tws_reg_slave u_tws_reg_slave (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .strap_sel (strap_sel),
        .busy      (busy),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (wr_stb) begin
            mem[wr_addr] <= wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (!rst && (sda_oe != prev_oe) && scl_m) viol = viol + 1;
        prev_oe = sda_oe;
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        m_low = 1'b1; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        m_low = 1'b0; w(Q);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b; w(Q);
        scl_m = 1'b1; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; w(Q);
        scl_m = 1'b1; w(Q / 2);
        b = sda_line; w(Q / 2);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; w(Q);
        scl_m = 1'b1; w(Q / 2);
        ack = !sda_line; w(Q / 2);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(!mack);
    endtask

    task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(A_W, ack);
        send_byte(a, ack);
        bus_start();
        send_byte(A_R, ack);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(A_R, ack);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        logic ack;
        chk("R12 sda_oe", sda_oe, 1'b0);
        chk("R12 wr_stb", wr_stb, 1'b0);
        bus_start();
        send_byte(A_R, ack);
        chk("R1 read address ack", ack, 1'b1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R12 pointer starts at 00", d, expm[0]);
    endtask

    task automatic t_single_write();
        logic [7:0] d;
        logic ack;
        int base = wr_cnt;
        bus_start();
        send_byte(A_W, ack);
        chk("R1 write address ack", ack, 1'b1);
        send_byte(8'h05, ack);
        chk("R4 pointer byte ack", ack, 1'b1);
        send_byte(8'h3C, ack);
        chk("R4 data byte ack", ack, 1'b1);
        bus_stop();
        expm[8'h05] = 8'h3C;
        chk("R4 one strobe", wr_cnt - base, 1);
        rand_read(8'h05, d);
        chk("R7 random read", d, 8'h3C);
        cur_read(d);
        chk("R6 current read", d, expm[8'h06]);
    endtask

    task automatic t_page();
        logic [7:0] d;
        logic ack;
        logic [7:0] vals [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        logic [7:0] adrs [5] = '{8'h1D, 8'h1E, 8'h1F, 8'h18, 8'h19};
        int base = wr_cnt;
        bus_start();
        send_byte(A_W, ack);
        send_byte(8'h1D, ack);
        for (int i = 0; i < 5; i++) begin
            send_byte(vals[i], ack);
            chk("R4 page data ack", ack, 1'b1);
            expm[adrs[i]] = vals[i];
        end
        bus_stop();
        chk("R5 strobe count", wr_cnt - base, 5);
        bus_start();
        send_byte(A_W, ack);
        send_byte(8'h18, ack);
        bus_start();
        send_byte(A_R, ack);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i != 7, d);
            chk("R5 page contents", d, expm[8'h18 + i]);
        end
        bus_stop();
        rand_read(8'h20, d);
        chk("R5 next page untouched", d, expm[8'h20]);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        logic ack;
        bus_start();
        send_byte(A_W, ack);
        send_byte(8'hFE, ack);
        bus_start();
        send_byte(A_R, ack);
        recv_byte(1'b1, d);
        chk("R8 byte FE", d, expm[8'hFE]);
        recv_byte(1'b1, d);
        chk("R8 byte FF", d, expm[8'hFF]);
        recv_byte(1'b0, d);
        chk("R8 wrap to 00", d, expm[8'h00]);
        bus_stop();
        cur_read(d);
        chk("R8 pointer after wrap", d, expm[8'h01]);
    endtask

    task automatic t_nack();
        logic [7:0] d;
        logic b;
        logic ack;
        bus_start();
        send_byte(A_W, ack);
        send_byte(8'h07, ack);
        bus_start();
        send_byte(A_R, ack);
        recv_byte(1'b0, d);
        recv_bit(b);
        chk("R9 line released after nack", b, 1'b1);
        bus_stop();
        cur_read(d);
        chk("R9 pointer after nack", d, expm[8'h08]);
    endtask

    task automatic t_mismatch();
        logic [7:0] d;
        logic ack;
        int base = wr_cnt;
        bus_start();
        send_byte(A_MM, ack);
        chk("R2 strap mismatch no ack", ack, 1'b0);
        send_byte(8'h30, ack);
        chk("R2 following byte no ack", ack, 1'b0);
        send_byte(8'h77, ack);
        bus_stop();
        chk("R2 no strobe", wr_cnt - base, 0);
        rand_read(8'h30, d);
        chk("R2 memory unchanged", d, expm[8'h30]);
        bus_start();
        send_byte(8'hB2, ack);
        chk("R1 wrong control code no ack", ack, 1'b0);
        bus_stop();
    endtask

    task automatic t_busy();
        logic [7:0] d;
        logic ack;
        busy = 1'b1;
        bus_start();
        send_byte(A_W, ack);
        chk("R3 busy no ack", ack, 1'b0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(A_W, ack);
        chk("R3 ack after busy", ack, 1'b1);
        send_byte(8'h40, ack);
        send_byte(8'h9A, ack);
        bus_stop();
        expm[8'h40] = 8'h9A;
        rand_read(8'h40, d);
        chk("R3 write after busy", d, 8'h9A);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        logic ack;
        int base;
        bus_start();
        send_byte(A_W, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        send_byte(A_W, ack);
        chk("R10 ack after restart", ack, 1'b1);
        send_byte(8'h10, ack);
        send_byte(8'hC3, ack);
        bus_stop();
        expm[8'h10] = 8'hC3;
        rand_read(8'h10, d);
        chk("R10 write after abort", d, 8'hC3);
        base = wr_cnt;
        bus_start();
        send_byte(A_W, ack);
        send_byte(8'h10, ack);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(A_R, ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R10 partial byte no strobe", wr_cnt - base, 0);
        chk("R10 read after partial", d, 8'hC3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'(i) ^ 8'h5A;
            expm[i] = 8'(i) ^ 8'h5A;
        end
        w(5);
        rst = 1'b0;
        w(5);
        t_reset();
        t_single_write();
        t_page();
        t_wrap();
        t_nack();
        t_mismatch();
        t_busy();
        t_abort();
        chk("R11 drive changed with clock high", viol, 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule